// File: doc/BRIEF.md
# Host PIO FIFO Read Port

This block lets an external processor read a receive-data FIFO over an asynchronous, SRAM-style bus by means of an active-low chip-select and an active-low read strobe. Both strobes pass through a two-flop synchronizer. A control state machine then detects where each read cycle starts and ends. A cycle is the logical AND of the two asserted strobes, and the strobes may fall and rise in any order.

When the FIFO-select input is high at the start of a cycle, no address is decoded. Every such cycle reads the head of the FIFO, so a host that steps its address through a burst still receives consecutive words. One word leaves the FIFO at the end of each completed cycle. In 16-bit mode a word leaves only after both of its halves have been read.

Bus-cycle limits are parameters in system clock cycles: the asserted length, the released length and the start-to-start period. Breaking any of them sets a sticky error flag. A FIFO write port fills the internal buffer.

The controller has two states. `S_IDLE` waits while the synchronized strobes are not both asserted. The START transition leads to `S_READ` on the first clock edge that sees both strobes asserted; it latches the select mode and the bus word and checks the released time and the period. `S_READ` holds while both strobes stay asserted. The END transition leads back to `S_IDLE` on the first edge that sees either strobe released; it pops or advances the half-word pointer and checks the asserted time.

Top module: `pio_fifo_rdport`

## Requirements
- R1: After reset, `rd_oe`, `rd_data`, `underflow_err` and `timing_err` are all zero.
- R2: With only one of `cs_n` or `rd_n` low, no cycle starts: `rd_oe` stays 0 and nothing is popped.
- R3: A cycle ends when either strobe rises, whichever rises first. `rd_oe` returns to 0 on the third rising clock edge after that release.
- R4: With `fifo_sel` high at cycle start, each cycle returns the FIFO head. Successive cycles return the words in the order they were pushed.
- R5: During the asserted phase `rd_oe` is 1 and `rd_data` is stable. Exactly one pop occurs per completed FIFO cycle, at its end.
- R6: With `half_mode` = 1, a read returns the word's bits [15:0] in `rd_data[15:0]` first, then bits [31:16], with `rd_data[31:16]` = 0. The word is popped after its upper half.
- R7: A FIFO-select cycle on an empty FIFO returns 0 and pops nothing. It sets `underflow_err`, which stays 1 until reset.
- R8: `timing_err` becomes 1 and stays 1 until reset if a cycle is asserted for fewer than MIN_ASSERT clocks, or if the strobes stay released fewer than MIN_DEASSERT clocks before the next start, or if start-to-start is fewer than MIN_CYCLE clocks.
- R9: A cycle with `fifo_sel` low returns 0 and does not pop.
- R10: `rd_oe` rises on the third rising clock edge after both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| fifo_sel | input | 1 | High selects direct FIFO access, sampled at cycle start |
| half_mode | input | 1 | 1 selects the 16-bit bus mode; change only during reset |
| push | input | 1 | Write one word into the FIFO (ignored when full) |
| push_data | input | DW | Word to write |
| rd_data | output | DW | Read data, valid while rd_oe is 1 |
| rd_oe | output | 1 | Data bus output enable |
| underflow_err | output | 1 | Sticky flag: FIFO read while empty |
| timing_err | output | 1 | Sticky flag: bus cycle limit violated |

## Verification
Directed cycles cover three strobe patterns: both strobes falling together, chip-select falling before the read strobe, and the read strobe rising before chip-select. Together these show that a cycle is framed by the AND of the two strobes and not by either one alone. Lone strobes and reads with `fifo_sel` low must leave the FIFO order untouched, which separates a true pop from a cycle that only drives the bus. Three reads just under the limits each break exactly one of the asserted, released and period rules. A random mix of lengths, orders and select values then runs in both bus widths against a queue model; the 16-bit run shows whether the pop waits for the upper half.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_READ = 1'b1
    } rd_state_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/pio_rx_fifo.sv
module pio_rx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [PW:0]   cnt_q;
    logic          full;
    logic          do_push, do_pop;

    assign full    = (cnt_q == (PW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= push_data;
    end

    AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty) else $error("pop on empty FIFO"); // R7
endmodule

// File: rtl/pio_rd_ctrl.sv
module pio_rd_ctrl
    import pio_rd_pkg::*;
#(
    parameter int DW           = 32,
    parameter int MIN_ASSERT   = 3,
    parameter int MIN_DEASSERT = 2,
    parameter int MIN_CYCLE    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          fifo_sel,
    input  logic          half_mode,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_head,
    output logic          pop,
    output logic          rd_oe,
    output logic [DW-1:0] rd_data,
    output logic          underflow_err,
    output logic          timing_err
);
    localparam int HW = DW / 2;
    localparam int CW = $clog2(MIN_CYCLE + MIN_ASSERT + MIN_DEASSERT + 2) + 1;

    rd_state_e     state_q, state_d;
    logic [CW-1:0] asrt_q, idle_q, per_q;
    logic          seen_q, fmode_q, uf_cur_q, half_q;
    logic          uflow_q, terr_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] sel_word;

    function automatic logic [CW-1:0] inc_sat(input logic [CW-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    assign sel_word = half_mode
        ? {{HW{1'b0}}, (half_q ? fifo_head[DW-1:HW] : fifo_head[HW-1:0])}
        : fifo_head;

    // next-state logic: START and END transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (active)  state_d = S_READ;
            S_READ: if (!active) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // per-cycle bookkeeping, data capture and limit checks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asrt_q   <= '0;
            idle_q   <= '0;
            per_q    <= '0;
            seen_q   <= 1'b0;
            fmode_q  <= 1'b0;
            uf_cur_q <= 1'b0;
            half_q   <= 1'b0;
            uflow_q  <= 1'b0;
            terr_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            per_q <= inc_sat(per_q);
            unique case (state_q)
                S_IDLE: begin
                    idle_q <= inc_sat(idle_q);
                    if (active) begin
                        if (seen_q && ((idle_q < CW'(MIN_DEASSERT)) ||
                                       (per_q  < CW'(MIN_CYCLE))))
                            terr_q <= 1'b1;
                        seen_q  <= 1'b1;
                        per_q   <= CW'(1);
                        asrt_q  <= CW'(1);
                        fmode_q <= fifo_sel;
                        if (fifo_sel && fifo_empty) begin
                            uf_cur_q <= 1'b1;
                            uflow_q  <= 1'b1;
                            data_q   <= '0;
                        end else begin
                            uf_cur_q <= 1'b0;
                            data_q   <= fifo_sel ? sel_word : '0;
                        end
                    end
                end
                S_READ: begin
                    if (active) begin
                        asrt_q <= inc_sat(asrt_q);
                    end else begin
                        if (asrt_q < CW'(MIN_ASSERT)) terr_q <= 1'b1;
                        idle_q <= CW'(1);
                        if (fmode_q && !uf_cur_q && half_mode)
                            half_q <= !half_q;
                    end
                end
            endcase
        end
    end

    always_comb begin
        pop = 1'b0;
        if (state_q == S_READ && !active && fmode_q && !uf_cur_q)
            pop = !half_mode || half_q;
    end

    assign rd_oe         = (state_q == S_READ);
    assign rd_data       = data_q;
    assign underflow_err = uflow_q;
    assign timing_err    = terr_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !active) |=> (state_q == S_IDLE)) else $error("start without strobes"); // R2
    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READ && !active) |=> !rd_oe) else $error("bus held after end"); // R3
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READ && active) |=> $stable(rd_data)) else $error("data moved mid-cycle"); // R5
    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err) else $error("underflow flag cleared"); // R7
    AST_TERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |=> timing_err) else $error("timing flag cleared"); // R8
endmodule

// File: rtl/pio_fifo_rdport.sv
module pio_fifo_rdport #(
    parameter int DW           = 32,
    parameter int DEPTH        = 8,
    parameter int MIN_ASSERT   = 3,
    parameter int MIN_DEASSERT = 2,
    parameter int MIN_CYCLE    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          fifo_sel,
    input  logic          half_mode,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_oe,
    output logic          underflow_err,
    output logic          timing_err
);
    logic [1:0]    strb_s;
    logic          active;
    logic          pop;
    logic          fifo_empty;
    logic [DW-1:0] fifo_head;

    pio_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rd_n}),
        .q     (strb_s)
    );

    assign active = ~strb_s[1] & ~strb_s[0];

    pio_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (fifo_head),
        .empty     (fifo_empty)
    );

    pio_rd_ctrl #(
        .DW           (DW),
        .MIN_ASSERT   (MIN_ASSERT),
        .MIN_DEASSERT (MIN_DEASSERT),
        .MIN_CYCLE    (MIN_CYCLE)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .fifo_sel      (fifo_sel),
        .half_mode     (half_mode),
        .fifo_empty    (fifo_empty),
        .fifo_head     (fifo_head),
        .pop           (pop),
        .rd_oe         (rd_oe),
        .rd_data       (rd_data),
        .underflow_err (underflow_err),
        .timing_err    (timing_err)
    );
endmodule

// File: tb/pio_fifo_rdport_tb.sv
module pio_fifo_rdport_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, rd_n, fifo_sel, half_mode, push;
    logic [31:0] push_data, rd_data;
    logic        rd_oe, underflow_err, timing_err;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] mq[$];
    bit          bhalf, buf_uf;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_fifo_rdport dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
        .fifo_sel(fifo_sel), .half_mode(half_mode), .push(push),
        .push_data(push_data), .rd_data(rd_data), .rd_oe(rd_oe),
        .underflow_err(underflow_err), .timing_err(timing_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input bit fs);
        if (!fs || mq.size() == 0) return 32'h0;
        if (!half_mode) return mq[0];
        return bhalf ? {16'h0, mq[0][31:16]} : {16'h0, mq[0][15:0]};
    endfunction

    task automatic do_reset(input bit hm);
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; fifo_sel = 1'b0;
        half_mode = hm; push = 1'b0; push_data = '0;
        mq.delete(); bhalf = 0; buf_uf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_push(input logic [31:0] w);
        push = 1'b1; push_data = w;
        @(negedge clk);
        push = 1'b0;
        if (mq.size() < 8) mq.push_back(w);
    endtask

    // one bus read; starts and ends at a falling clock edge
    task automatic rd_cycle(input int alen, input int dlen, input bit stag_a,
                            input bit stag_d, input bit fs, input bit chk);
        logic [31:0] exp;
        exp = exp_word(fs);
        fifo_sel = fs;
        cs_n = 1'b0;
        if (stag_a) @(negedge clk);
        rd_n = 1'b0;
        repeat (alen) @(negedge clk);
        if (chk) begin
            check("R5 oe asserted", {31'h0, rd_oe}, 32'h1);
            check(half_mode ? "R6 half word" : (fs ? "R4 fifo word" : "R9 non-fifo zero"), rd_data, exp);
        end
        if (stag_d) begin
            rd_n = 1'b1; @(negedge clk); cs_n = 1'b1;
            repeat (dlen - 1) @(negedge clk);
        end else begin
            rd_n = 1'b1; cs_n = 1'b1;
            repeat (dlen) @(negedge clk);
        end
        if (chk && dlen >= 3) check("R3 bus released", {31'h0, rd_oe}, 32'h0);
        if (fs) begin
            if (mq.size() == 0) buf_uf = 1;
            else if (!half_mode || bhalf) begin
                void'(mq.pop_front());
                if (half_mode) bhalf = 0;
            end else bhalf = 1;
        end
        if (chk) check("R7 underflow flag", {31'h0, underflow_err}, {31'h0, buf_uf});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        do_reset(1'b0);
        // R1 reset state
        check("R1 rd_oe", {31'h0, rd_oe}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 underflow", {31'h0, underflow_err}, 32'h0);
        check("R1 timing", {31'h0, timing_err}, 32'h0);

        do_push(32'hA1B2C3D4); do_push(32'h11223344); do_push(32'h55667788);

        // R2 lone strobes
        fifo_sel = 1'b1; cs_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R2 cs only", {31'h0, rd_oe}, 32'h0);
        cs_n = 1'b1; repeat (3) @(negedge clk);
        rd_n = 1'b0; repeat (6) @(negedge clk);
        check("R2 rd only", {31'h0, rd_oe}, 32'h0);
        rd_n = 1'b1; repeat (3) @(negedge clk);

        // R10 latency
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 oe not yet", {31'h0, rd_oe}, 32'h0);
        @(negedge clk);
        check("R10 oe on third edge", {31'h0, rd_oe}, 32'h1);
        check("R4 first word after lone strobes", rd_data, 32'hA1B2C3D4);
        @(negedge clk);
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 oe held two edges", {31'h0, rd_oe}, 32'h1);
        cs_n = 1'b1;
        @(negedge clk);
        check("R3 oe drops on third edge", {31'h0, rd_oe}, 32'h0);
        void'(mq.pop_front());
        repeat (3) @(negedge clk);

        // R9 non-fifo read, then staggered orders
        rd_cycle(4, 4, 0, 0, 0, 1);
        rd_cycle(4, 4, 1, 0, 1, 1);
        rd_cycle(4, 4, 0, 1, 1, 1);
        // R7 empty read
        rd_cycle(4, 4, 0, 0, 1, 1);
        check("R7 read zero", rd_data, 32'h0);
        check("R8 no timing error so far", {31'h0, timing_err}, 32'h0);

        // R8 short assert
        do_reset(1'b0); do_push(32'h1);
        rd_cycle(2, 4, 0, 0, 1, 0);
        check("R8 short assert", {31'h0, timing_err}, 32'h1);
        // R8 short deassert
        do_reset(1'b0); do_push(32'h1); do_push(32'h2);
        rd_cycle(6, 1, 0, 0, 1, 0);
        rd_cycle(6, 4, 0, 0, 1, 0);
        check("R8 short release", {31'h0, timing_err}, 32'h1);
        // R8 short period only
        do_reset(1'b0); do_push(32'h1); do_push(32'h2);
        rd_cycle(3, 2, 0, 0, 1, 0);
        rd_cycle(3, 4, 0, 0, 1, 0);
        check("R8 short period", {31'h0, timing_err}, 32'h1);
        // R8 limits met exactly
        do_reset(1'b0); do_push(32'h1); do_push(32'h2);
        rd_cycle(3, 3, 0, 0, 1, 0);
        rd_cycle(3, 4, 0, 0, 1, 0);
        check("R8 at limits", {31'h0, timing_err}, 32'h0);

        // random mix, both bus widths
        for (int ph = 0; ph < 2; ph++) begin
            do_reset(ph[0]);
            for (int i = 0; i < 40; i++) begin
                if (mq.size() < 6 && $urandom_range(0, 2) != 0) do_push($urandom());
                rd_cycle($urandom_range(3, 6), $urandom_range(3, 5),
                         1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                         ($urandom_range(0, 4) != 0), 1);
            end
            check("R8 random no error", {31'h0, timing_err}, 32'h0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule